// File: doc/BRIEF.md
# Interrupt Sense Normalizing Forwarder

This block takes a bank of external interrupt pins and hands each one to a parent interrupt controller. The parent accepts only two forms: a rising-edge pulse or an active-high level. Each pin has a 3-bit sense code that says how to read it. The choices are active-low level, active-high level, falling edge, rising edge or both edges. The block turns every form into one the parent accepts and drives one output line per pin. A per-pin enable bit can mask any pin. A masked pin's output stays low.

Every pin is resynchronized to the block clock through two flops before it is read. An edge is found by comparing the synchronized value with its value one cycle earlier. Each edge becomes a one-cycle high pulse on the output line, which the parent sees as a rising edge.

Software sets the enables and the sense codes over a 32-bit register port. The port has a write strobe and a read strobe, a byte address, write data and registered read data.

Top module: `irq_sense_fwd`

## Requirements
- R1: During reset and after it, every enable bit is 0, every sense code is 3'b100, every output is low and read data is 0.
- R2: The enable bit of pin n is bit n%32 of the word at byte address 0x10 + 4*(n/32). A write to that word replaces all of its bits. Bits that belong to no pin (pins 126 and 127) read as 0.
- R3: The sense code of pin n is the low 3 bits of the word at byte address 0x110 + 4*n. A write stores wdata[2:0]. Bits 31:3 read as 0.
- R4: With code 3'b000 (low level) and the pin enabled, the output is the inverse of the synchronized pin.
- R5: With code 3'b100 (high level) and the pin enabled, the output equals the synchronized pin.
- R6: With code 3'b010 (falling edge) and the pin enabled, a high-to-low change on the pin gives an output pulse exactly one clock long.
- R7: With code 3'b110 (rising edge) and the pin enabled, a low-to-high change gives an output pulse exactly one clock long.
- R8: With code 3'b111 (dual edge) and the pin enabled, a change in either direction gives an output pulse exactly one clock long.
- R9: A pin whose enable bit is 0 has its output held low, whatever its code or input.
- R10: The codes 3'b001, 3'b011 and 3'b101 hold the output low.
- R11: Any address that is not word-aligned, or that falls outside both register arrays, reads as 0 and ignores writes.
- R12: A pin value present at clock edge k is the synchronized value from edge k+2 on. Read data appears at the clock edge that samples rd_en_i, using register contents from before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| pins_i | input | 126 | External interrupt pins |
| irq_o | output | 126 | Normalized lines to the parent controller |

## Verification
The assertions compare each output with the pin value sampled two and three edges earlier. This assumes that every pin settles cleanly between clock edges, so that the synchronizer never goes metastable and its output is the pin delayed by exactly two edges. The stimulus meets this by changing pins, strobes, address and data only on the falling clock edge, far from the sampling edge. The assertions also assume that reset lasts at least one edge. The bench holds it for several.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int REG_W   = 32;
  localparam int SENSE_W = 3;

  localparam int EN_BASE  = 'h10;
  localparam int CFG_BASE = 'h110;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LVL_LO    = 3'b000,
    SENSE_EDGE_FALL = 3'b010,
    SENSE_LVL_HI    = 3'b100,
    SENSE_EDGE_RISE = 3'b110,
    SENSE_EDGE_BOTH = 3'b111
  } sense_e;

  localparam logic [SENSE_W-1:0] SENSE_RESET = 3'b100;

endpackage

// File: rtl/irq_sense_sync.sv
module irq_sense_sync #(
  parameter int WIDTH  = 126,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int k = 1; k < STAGES; k++) begin
      stg_d[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/irq_sense_lane.sv
module irq_sense_lane
  import irq_sense_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_i,
  input  logic               en_i,
  input  logic [SENSE_W-1:0] code_i,
  output logic               irq_o
);

  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;
  logic fwd;

  always_comb begin
    prev_d = sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise = sync_i & ~prev_q;
    fall = ~sync_i & prev_q;
    case (code_i)
      SENSE_LVL_LO:    fwd = ~sync_i;
      SENSE_LVL_HI:    fwd = sync_i;
      SENSE_EDGE_FALL: fwd = fall;
      SENSE_EDGE_RISE: fwd = rise;
      SENSE_EDGE_BOTH: fwd = rise | fall;
      default:         fwd = 1'b0;
    endcase
  end

  assign irq_o = en_i & fwd;

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import irq_sense_pkg::*;
#(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [REG_W-1:0]                  wdata_i,
  output logic [REG_W-1:0]                  rdata_o,
  output logic [NUM_PINS-1:0]               en_o,
  output logic [NUM_PINS-1:0][SENSE_W-1:0]  cfg_o
);

  localparam int NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * NUM_WORDS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * NUM_PINS);

  logic [NUM_PINS-1:0]               en_q;
  logic [NUM_PINS-1:0]               en_d;
  logic [NUM_PINS-1:0][SENSE_W-1:0]  cfg_q;
  logic [NUM_PINS-1:0][SENSE_W-1:0]  cfg_d;
  logic [REG_W-1:0]                  rdata_q;
  logic [REG_W-1:0]                  rd_d;

  logic              aligned;
  logic              en_hit;
  logic              cfg_hit;
  logic [WORD_W-1:0] en_word;
  logic [IDX_W-1:0]  cfg_idx;

  logic [NUM_WORDS-1:0][REG_W-1:0] en_words;

  // address decode
  always_comb begin
    aligned = (addr_i[1:0] == 2'b00);
    en_hit  = aligned && (addr_i >= EN_LO) && (addr_i < EN_HI);
    cfg_hit = aligned && (addr_i >= CFG_LO) && (addr_i < CFG_HI);
    en_word = addr_i[WORD_W+1:2] - EN_LO[WORD_W+1:2];
    cfg_idx = addr_i[IDX_W+1:2] - CFG_LO[IDX_W+1:2];
  end

  // enable words as seen by software, unused bits tied low
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (w * REG_W + b < NUM_PINS) begin : g_live
        assign en_words[w][b] = en_q[w*REG_W+b];
      end else begin : g_pad
        assign en_words[w][b] = 1'b0;
      end
    end
  end

  // next state
  always_comb begin
    en_d  = en_q;
    cfg_d = cfg_q;
    if (wr_en_i && en_hit) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (en_word == WORD_W'(p / REG_W)) begin
          en_d[p] = wdata_i[p%REG_W];
        end
      end
    end
    if (wr_en_i && cfg_hit) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (cfg_idx == IDX_W'(p)) begin
          cfg_d[p] = wdata_i[SENSE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (en_hit) begin
      rd_d = en_words[en_word];
    end else if (cfg_hit) begin
      rd_d = {{(REG_W-SENSE_W){1'b0}}, cfg_q[cfg_idx]};
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= {NUM_PINS{SENSE_RESET}};
    end else begin
      en_q  <= en_d;
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign cfg_o   = cfg_q;

endmodule

// File: rtl/irq_sense_fwd.sv
module irq_sense_fwd
  import irq_sense_pkg::*;
#(
  parameter int NUM_PINS    = 126,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] irq_o
);

  logic [NUM_PINS-1:0]              en_bits;
  logic [NUM_PINS-1:0][SENSE_W-1:0] cfg_bits;
  logic [NUM_PINS-1:0]              sync_val;

  irq_sense_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en_bits),
    .cfg_o   (cfg_bits)
  );

  irq_sense_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_i),
    .dout  (sync_val)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    irq_sense_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (sync_val[i]),
      .en_i   (en_bits[i]),
      .code_i (cfg_bits[i]),
      .irq_o  (irq_o[i])
    );
  end

endmodule

// File: rtl/irq_sense_fwd_chk.sv
module irq_sense_fwd_chk #(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_PINS-1:0]       pins_i,
  input logic [NUM_PINS-1:0]       irq_o,
  input logic [NUM_PINS-1:0]       en_bits,
  input logic [NUM_PINS-1:0][2:0]  cfg_bits,
  input logic                      rd_en_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [31:0]               rdata_o
);

  localparam int NW = (NUM_PINS + 31) / 32;

  logic [1:0] age_q;
  logic       in_en;
  logic       in_cfg;
  int         a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  always_comb begin
    a      = int'(addr_i);
    in_en  = (a % 4 == 0) && (a >= 'h10) && (a < 'h10 + 4 * NW);
    in_cfg = (a % 4 == 0) && (a >= 'h110) && (a < 'h110 + 4 * NUM_PINS);
  end

  // R11
  oom_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !in_en && !in_cfg) |=> (rdata_o == 32'h0));

  // R3
  cfg_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && in_cfg) |=> (rdata_o[31:3] == 29'h0));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    // R9
    mask_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_bits[g] |-> !irq_o[g]);

    // R4
    lvl_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && en_bits[g] && cfg_bits[g] == 3'b000)
        |-> (irq_o[g] == !$past(pins_i[g], 2)));

    // R5
    lvl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && en_bits[g] && cfg_bits[g] == 3'b100)
        |-> (irq_o[g] == $past(pins_i[g], 2)));

    // R6
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && en_bits[g] && cfg_bits[g] == 3'b010)
        |-> (irq_o[g] == (!$past(pins_i[g], 2) && $past(pins_i[g], 3))));

    // R7
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && en_bits[g] && cfg_bits[g] == 3'b110)
        |-> (irq_o[g] == ($past(pins_i[g], 2) && !$past(pins_i[g], 3))));

    // R8
    dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd3 && en_bits[g] && cfg_bits[g] == 3'b111)
        |-> (irq_o[g] == ($past(pins_i[g], 2) != $past(pins_i[g], 3))));

    // R10
    undef_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bits[g] == 3'b001 || cfg_bits[g] == 3'b011 || cfg_bits[g] == 3'b101)
        |-> !irq_o[g]);
  end

endmodule

bind irq_sense_fwd irq_sense_fwd_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pins_i   (pins_i),
  .irq_o    (irq_o),
  .en_bits  (en_bits),
  .cfg_bits (cfg_bits),
  .rd_en_i  (rd_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o)
);

// File: tb/irq_sense_fwd_tb.sv
module irq_sense_fwd_tb;

  localparam int NP = 126;
  localparam int AW = 12;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  wire  [31:0]   rdata;
  logic [NP-1:0] pins;
  wire  [NP-1:0] irq;
  logic          tog_on;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_sense_fwd u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pins_i  (pins),
    .irq_o   (irq)
  );

  // behavioural model state
  bit            en_m  [NP];
  bit [2:0]      cfg_m [NP];
  logic [NP-1:0] hist[$];
  logic [31:0]   exp_rd;
  string         rd_lbl;
  bit            fresh;

  function automatic logic [31:0] mread(input logic [AW-1:0] ad);
    int ai;
    logic [31:0] v;
    ai = int'(ad);
    v  = '0;
    if (ai % 4 == 0 && ai >= 16 && ai < 16 + 4 * NW) begin
      for (int b = 0; b < 32; b++) begin
        if (((ai - 16) / 4) * 32 + b < NP) v[b] = en_m[((ai - 16) / 4) * 32 + b];
      end
    end else if (ai % 4 == 0 && ai >= 272 && ai < 272 + 4 * NP) begin
      v[2:0] = cfg_m[(ai - 272) / 4];
    end
    return v;
  endfunction

  function automatic string rlabel(input logic [AW-1:0] ad);
    int ai;
    ai = int'(ad);
    if (fresh) return "R1 R12";
    if (ai % 4 == 0 && ai >= 16 && ai < 16 + 4 * NW) return "R2 R12";
    if (ai % 4 == 0 && ai >= 272 && ai < 272 + 4 * NP) return "R3 R12";
    return "R11";
  endfunction

  function automatic bit exp_pin(input int i);
    bit s;
    bit p;
    s = hist[1][i];
    p = hist[2][i];
    if (!en_m[i]) return 1'b0;
    case (cfg_m[i])
      3'b000:  return !s;
      3'b100:  return s;
      3'b010:  return p && !s;
      3'b110:  return s && !p;
      3'b111:  return s != p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string plabel(input int i);
    if (fresh) return "R1";
    if (!en_m[i]) return "R9";
    case (cfg_m[i])
      3'b000:  return "R4 R12";
      3'b100:  return "R5 R12";
      3'b010:  return "R6 R12";
      3'b110:  return "R7 R12";
      3'b111:  return "R8 R12";
      default: return "R10";
    endcase
  endfunction

  // model update at each edge, comparison 5 ns later
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) begin
        en_m[i]  = 1'b0;
        cfg_m[i] = 3'b100;
      end
      exp_rd = '0;
      fresh  = 1'b1;
      rd_lbl = "R1";
      hist.push_front('0);
    end else begin
      if (rd_en) begin
        exp_rd = mread(addr);
        rd_lbl = rlabel(addr);
      end
      if (wr_en) begin
        int ai;
        ai    = int'(addr);
        fresh = 1'b0;
        if (ai % 4 == 0 && ai >= 16 && ai < 16 + 4 * NW) begin
          for (int b = 0; b < 32; b++) begin
            if (((ai - 16) / 4) * 32 + b < NP) en_m[((ai - 16) / 4) * 32 + b] = wdata[b];
          end
        end else if (ai % 4 == 0 && ai >= 272 && ai < 272 + 4 * NP) begin
          cfg_m[(ai - 272) / 4] = wdata[2:0];
        end
      end
      hist.push_front(pins);
    end
    while (hist.size() > 3) void'(hist.pop_back());
    #5;
    if (hist.size() == 3) begin
      for (int i = 0; i < NP; i++) begin
        checks++;
        if (irq[i] !== exp_pin(i)) begin
          fails++;
          $display("FAIL %s pin %0d irq actual=%b expected=%b at %0t",
                   plabel(i), i, irq[i], exp_pin(i), $time);
        end
      end
    end
    checks++;
    if (rdata !== exp_rd) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h at %0t", rd_lbl, rdata, exp_rd, $time);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = AW'(a);
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    rd_en = 1'b1;
    addr  = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // pin stimulus: sparse random toggles on falling edges
  initial begin
    logic [127:0] r1;
    logic [127:0] r2;
    pins = '0;
    forever begin
      @(negedge clk);
      if (tog_on) begin
        r1 = {$urandom, $urandom, $urandom, $urandom};
        r2 = {$urandom, $urandom, $urandom, $urandom};
        pins = pins ^ (r1[NP-1:0] & r2[NP-1:0]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    addr   = '0;
    wdata  = '0;
    tog_on = 1'b0;
    repeat (3) @(negedge clk);
    tog_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: reset contents read back
    rd('h10); rd('h14); rd('h1C); rd('h110); rd('h110 + 4 * 125);

    // R2: enable every pin, padding bits of the last word stay 0
    for (int w = 0; w < NW; w++) wr('h10 + 4 * w, 32'hFFFF_FFFF);
    rd('h1C); rd('h10);
    repeat (60) @(negedge clk);   // R5 default level high

    // R4..R8, R10: rotate codes across all pins
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < NP; i++) wr('h110 + 4 * i, 32'((i * 3 + ph * 5) % 8));
      repeat (150) @(negedge clk);
      rd('h110 + 4 * ph);
      rd('h110 + 4 * (NP - 1 - ph));
    end

    // R9: partial masking
    wr('h10, 32'h5555_5555);
    wr('h14, 32'h0F0F_F0F0);
    wr('h18, 32'h0000_0000);
    wr('h1C, 32'hC000_0001);
    repeat (100) @(negedge clk);
    rd('h10); rd('h14); rd('h18); rd('h1C);

    // R11: out-of-map and unaligned accesses
    wr('h000, 32'hFFFF_FFFF);
    wr('h00C, 32'hFFFF_FFFF);
    wr('h020, 32'hFFFF_FFFF);
    wr('h10C, 32'hFFFF_FFFF);
    wr('h308, 32'h0000_0005);
    wr('h111, 32'h0000_0000);
    wr('h012, 32'h0000_0000);
    wr('hFFC, 32'hFFFF_FFFF);
    rd('h000); rd('h00C); rd('h020); rd('h10C); rd('h308); rd('h111); rd('hFFC);
    rd('h10); rd('h110);
    repeat (50) @(negedge clk);

    // R3: upper write bits dropped
    wr('h118, 32'hFFFF_FFF2);
    rd('h118);
    wr('h10, 32'hFFFF_FFFF);
    repeat (100) @(negedge clk);

    tog_on = 1'b0;
    repeat (10) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule